// File: doc/BRIEF.md
# Video Memory Contention Delay Unit

This block follows the position of the CPU clock inside a raster frame of a retro home computer. For every CPU memory access that lands in a contended 16 KB bank, it reports how many wait cycles the video logic would insert. One clock of the block is one CPU cycle. A free-running frame position counter walks the frame. A two-bit model code picks one of three timing variants. Each variant sets the line length, the frame height, the contention lead-in, the width of the contended span inside a line and the repeating eight-entry delay pattern.

The CPU side raises an access strobe with a 16-bit address. One clock later the block returns a three-bit delay. The delay is non-zero only under all of these conditions:

- the bank is marked contended;
- the shifted position falls on one of the first 192 display lines;
- the shifted position falls inside the contended span of that line.

The block also raises a frame interrupt a fixed number of cycles before the first video fetch of each frame, and holds it for 32 cycles.

Top module: `vid_contention_unit`

## Requirements
- R1: While `rst_ni` is low (synchronous, active low), `delay_o` and `irq_o` read 0. The model code is captured and the frame position P is set to 0.
- R2: Model code 0 gives 224 cycles per line and 312 lines per frame. Codes 1 and 2 give 228 cycles per line and 311 lines. Code 3 behaves as code 0. P advances by one each clock and wraps to 0 at the frame length (cycles per line × lines).
- R3: `delay_o` is registered. It shows the result for an access sampled at the previous rising edge, and it is 0 after any edge with `acc_valid_i` low.
- R4: The contended bank is `acc_addr_i[15:14]`. An access gets a delay only if `bank_mask_i` has that bank's bit set; otherwise `delay_o` is 0.
- R5: The delay is looked up at the shifted position S = (P + L) mod frame length. L is 4 for codes 0, 1 and 3, and 6 for code 2. Line = S div line length; column = S mod line length.
- R6: For codes 0, 1 and 3, the delay for column c inside the window is entry (c mod 8) of the sequence 6,5,4,3,2,1,0,0.
- R7: For code 2, the delay for column c inside the window is entry (c mod 8) of the sequence 1,0,7,6,5,4,3,2.
- R8: The delay is 0 when line ≥ 192 or when column ≥ W. W is 128 for codes 0, 1 and 3, and 129 for code 2.
- R9: `irq_o` goes high after the rising edge at which P equals frame length − K. K is 14335 for code 0/3, 14361 for code 1 and 14365 for code 2. It stays high for exactly 32 clocks.
- R10: When `model_sel_i` differs from the captured code at a rising edge out of reset, the new code is captured and P restarts at 0. The outputs produced at that edge still use the old code and position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU clock, one tick per CPU cycle |
| rst_ni | input | 1 | Synchronous reset, active low |
| model_sel_i | input | 2 | Timing variant code |
| bank_mask_i | input | 4 | One bit per 16 KB bank, 1 = contended |
| acc_valid_i | input | 1 | CPU memory access strobe |
| acc_addr_i | input | 16 | Address of the access |
| delay_o | output | 3 | Wait cycles for the access of the previous clock |
| irq_o | output | 1 | Frame interrupt, 32 cycles wide |

## Verification
Timing of the two results:

- **Delay:** `delay_o` is due one clock after the rising edge that sampled the strobe. It is computed from the frame position held before that edge.
- **Interrupt:** `irq_o` rises one clock after the edge at which the position equals its target. It falls 32 clocks later.

How the bench keeps to that timing:

- At every rising edge, a behavioural model works out both expected results from the inputs and its own integer position. It then advances that position, applying wrap and model restart.
- The DUT outputs are compared with the model on the following falling edge, when both results have settled and no input is changing.
- The stimulus runs past a full frame wrap for the first model. It then switches the model twice in mid-frame, so that each variant reaches its interrupt.

// File: rtl/vcu_pkg.sv
package vcu_pkg;

    localparam int COL_W         = 8;   // column within a line (< 256)
    localparam int LINE_W        = 9;   // line within a frame (< 512)
    localparam int DLY_W         = 3;   // wait-cycle count
    localparam int ADDR_W        = 16;
    localparam int BANKS         = 4;
    localparam int BANK_W        = $clog2(BANKS);
    localparam int PAT_LEN       = 8;
    localparam int IDX_W         = $clog2(PAT_LEN);
    localparam int DISPLAY_LINES = 192;
    localparam int MODEL_W       = 2;
    localparam int STD_PEAK      = 6;   // first entry of the standard ramp
    localparam int ALT_WRAP      = 9;   // ramp base of the alternate pattern

    // All timing constants of one variant, in shifted (lead-in) coordinates.
    typedef struct packed {
        logic [COL_W-1:0]  line_cycles;
        logic [LINE_W-1:0] frame_lines;
        logic [COL_W-1:0]  lead_in;
        logic [COL_W-1:0]  span;
        logic [LINE_W-1:0] irq_line;
        logic [COL_W-1:0]  irq_col;
        logic              alt_pattern;
    } timing_t;

    function automatic timing_t make_timing(input int cpl, input int lpf, input int lead,
                                            input int wid, input int irq_ahead, input logic alt);
        timing_t t;
        int      target;
        // Interrupt position P = frame - irq_ahead, seen at S = P + lead.
        target        = cpl * lpf - irq_ahead + lead;
        t.line_cycles = COL_W'(cpl);
        t.frame_lines = LINE_W'(lpf);
        t.lead_in     = COL_W'(lead);
        t.span        = COL_W'(wid);
        t.irq_line    = LINE_W'(target / cpl);
        t.irq_col     = COL_W'(target % cpl);
        t.alt_pattern = alt;
        return t;
    endfunction

    function automatic timing_t timing_of(input logic [MODEL_W-1:0] sel);
        timing_t t;
        case (sel)
            2'd1:    t = make_timing(228, 311, 4, 128, 14361, 1'b0);
            2'd2:    t = make_timing(228, 311, 6, 129, 14365, 1'b1);
            default: t = make_timing(224, 312, 4, 128, 14335, 1'b0);
        endcase
        return t;
    endfunction

    // Delay pattern computed from the column index rather than stored.
    function automatic logic [DLY_W-1:0] pattern_delay(input logic alt, input logic [IDX_W-1:0] idx);
        logic [DLY_W-1:0] d;
        if (!alt) begin
            d = (idx < IDX_W'(STD_PEAK)) ? DLY_W'(STD_PEAK - int'(idx)) : '0;
        end else if (idx == '0) begin
            d = DLY_W'(1);
        end else if (idx == IDX_W'(1)) begin
            d = '0;
        end else begin
            d = DLY_W'(ALT_WRAP - int'(idx));
        end
        return d;
    endfunction

endpackage

// File: rtl/vcu_frame_pos.sv
module vcu_frame_pos
    import vcu_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [MODEL_W-1:0] model_sel_i,
    output logic [COL_W-1:0]   col_o,
    output logic [LINE_W-1:0]  line_o,
    output logic [COL_W-1:0]   span_o,
    output logic               alt_o,
    output logic               irq_hit_o
);

    typedef struct packed {
        logic [MODEL_W-1:0] model;
        logic [COL_W-1:0]   col;
        logic [LINE_W-1:0]  line;
    } pos_t;

    pos_t    pos_d, pos_q, pos_rst;
    timing_t tm_q, tm_sel;
    logic    restart;

    always_comb begin
        tm_q    = timing_of(pos_q.model);
        tm_sel  = timing_of(model_sel_i);
        restart = (model_sel_i != pos_q.model);

        // Position 0 of the frame sits at shifted column lead_in of line 0.
        pos_rst.model = model_sel_i;
        pos_rst.col   = tm_sel.lead_in;
        pos_rst.line  = '0;

        pos_d = pos_q;
        if (restart) begin
            pos_d = pos_rst;
        end else if (pos_q.col == tm_q.line_cycles - 1'b1) begin
            pos_d.col  = '0;
            pos_d.line = (pos_q.line == tm_q.frame_lines - 1'b1) ? '0 : pos_q.line + 1'b1;
        end else begin
            pos_d.col = pos_q.col + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pos_q <= pos_rst;
        else         pos_q <= pos_d;
    end

    assign col_o     = pos_q.col;
    assign line_o    = pos_q.line;
    assign span_o    = tm_q.span;
    assign alt_o     = tm_q.alt_pattern;
    assign irq_hit_o = (pos_q.line == tm_q.irq_line) && (pos_q.col == tm_q.irq_col);

    AST_COL_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!restart && pos_q.col != tm_q.line_cycles - 1'b1) |=> (pos_q.col == COL_W'($past(pos_q.col) + 1'b1))); // R2
    AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!restart && pos_q.line == tm_q.frame_lines - 1'b1 && pos_q.col == tm_q.line_cycles - 1'b1)
        |=> (pos_q.line == '0 && pos_q.col == '0)); // R2
    AST_RESTART_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart |=> (pos_q.line == '0 && pos_q.col == tm_q.lead_in && pos_q.model == $past(model_sel_i))); // R10

endmodule

// File: rtl/vcu_delay_calc.sv
module vcu_delay_calc
    import vcu_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [COL_W-1:0]  col_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [COL_W-1:0]  span_i,
    input  logic              alt_i,
    input  logic [BANKS-1:0]  bank_mask_i,
    input  logic              acc_valid_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [DLY_W-1:0]  delay_o
);

    typedef struct packed {
        logic [DLY_W-1:0] delay;
    } dly_t;

    dly_t dly_d, dly_q;
    logic in_window;
    logic contended;

    always_comb begin
        in_window = (line_i < LINE_W'(DISPLAY_LINES)) && (col_i < span_i);
        contended = acc_valid_i && bank_mask_i[bank_i];
        dly_d.delay = '0;
        if (contended && in_window) begin
            dly_d.delay = pattern_delay(alt_i, col_i[IDX_W-1:0]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) dly_q <= '0;
        else         dly_q <= dly_d;
    end

    assign delay_o = dly_q.delay;

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc_valid_i |=> (delay_o == '0)); // R3
    AST_UNCONTENDED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && !bank_mask_i[bank_i]) |=> (delay_o == '0)); // R4
    AST_BORDER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_i >= LINE_W'(DISPLAY_LINES)) |=> (delay_o == '0)); // R8
    AST_STD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && !alt_i) |=> (delay_o <= DLY_W'(STD_PEAK))); // R6

endmodule

// File: rtl/vcu_irq_gen.sv
module vcu_irq_gen #(
    parameter int IRQ_LEN = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    output logic irq_o
);

    localparam int CNT_W = $clog2(IRQ_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (hit_i)                   irq_d.remain = CNT_W'(IRQ_LEN);
        else if (irq_q.remain != '0) irq_d.remain = irq_q.remain - 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_q <= '0;
        else         irq_q <= irq_d;
    end

    assign irq_o = (irq_q.remain != '0);

    AST_IRQ_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(hit_i)); // R9
    AST_HIT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_i |=> irq_o); // R9

endmodule

// File: rtl/vid_contention_unit.sv
module vid_contention_unit
    import vcu_pkg::*;
#(
    parameter int IRQ_LEN = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [MODEL_W-1:0] model_sel_i,
    input  logic [BANKS-1:0]   bank_mask_i,
    input  logic               acc_valid_i,
    input  logic [ADDR_W-1:0]  acc_addr_i,
    output logic [DLY_W-1:0]   delay_o,
    output logic               irq_o
);

    logic [COL_W-1:0]        col;
    logic [LINE_W-1:0]       line;
    logic [COL_W-1:0]        span;
    logic                    alt;
    logic                    irq_hit;
    logic [BANK_W-1:0]       bank;
    logic [ADDR_W-BANK_W-1:0] unused_low_addr;

    assign bank            = acc_addr_i[ADDR_W-1 -: BANK_W];
    assign unused_low_addr = acc_addr_i[ADDR_W-BANK_W-1:0];

    vcu_frame_pos u_pos (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .model_sel_i (model_sel_i),
        .col_o       (col),
        .line_o      (line),
        .span_o      (span),
        .alt_o       (alt),
        .irq_hit_o   (irq_hit)
    );

    vcu_delay_calc u_dly (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .col_i       (col),
        .line_i      (line),
        .span_i      (span),
        .alt_i       (alt),
        .bank_mask_i (bank_mask_i),
        .acc_valid_i (acc_valid_i),
        .bank_i      (bank),
        .delay_o     (delay_o)
    );

    vcu_irq_gen #(.IRQ_LEN(IRQ_LEN)) u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hit_i  (irq_hit),
        .irq_o  (irq_o)
    );

endmodule

// File: tb/vid_contention_unit_bench.sv
`timescale 1ns/1ps
module vid_contention_unit_bench;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [1:0]  model_sel = 2'd0;
    logic [3:0]  bank_mask = 4'b0110;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [2:0]  delay_o;
    logic        irq_o;

    always #2 clk = ~clk;   // 250 MHz

    vid_contention_unit u_vid_contention_unit (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .model_sel_i (model_sel),
        .bank_mask_i (bank_mask),
        .acc_valid_i (acc_valid),
        .acc_addr_i  (acc_addr),
        .delay_o     (delay_o),
        .irq_o       (irq_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int irq_rises = 0;
    bit cmp_en   = 0;

    // Reference model state
    int    ref_pos = 0;
    int    ref_model = 0;
    int    ref_cnt = 0;
    int    exp_delay = 0;
    int    exp_irq = 0;
    int    restart_tag = 0;
    string exp_tag = "R1";
    bit    prev_irq = 0;

    function automatic int eff(input int m);  return (m == 3) ? 0 : m; endfunction
    function automatic int cpl_of(input int m);   return (eff(m) == 0) ? 224 : 228; endfunction
    function automatic int lines_of(input int m); return (eff(m) == 0) ? 312 : 311; endfunction
    function automatic int lead_of(input int m);  return (eff(m) == 2) ? 6 : 4; endfunction
    function automatic int span_of(input int m);  return (eff(m) == 2) ? 129 : 128; endfunction
    function automatic int ahead_of(input int m);
        case (eff(m)) 1: return 14361; 2: return 14365; default: return 14335; endcase
    endfunction
    function automatic int seq_std(input int i);
        case (i) 0: return 6; 1: return 5; 2: return 4; 3: return 3; 4: return 2; 5: return 1; default: return 0; endcase
    endfunction
    function automatic int seq_alt(input int i);
        case (i) 0: return 1; 1: return 0; 2: return 7; 3: return 6; 4: return 5; 5: return 4; 6: return 3; default: return 2; endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    // Reference: evaluated at each rising edge from pre-edge state.
    always @(posedge clk) begin
        cycles++;
        if (!rst_ni) begin
            ref_pos = 0; ref_model = int'(model_sel); ref_cnt = 0;
            exp_delay = 0; exp_irq = 0; exp_tag = "R1";
        end else begin
            int frame, s, ln, col;
            frame = cpl_of(ref_model) * lines_of(ref_model);
            s   = (ref_pos + lead_of(ref_model)) % frame;   // R5
            ln  = s / cpl_of(ref_model);
            col = s % cpl_of(ref_model);
            if (!acc_valid) begin
                exp_delay = 0; exp_tag = "R3";
            end else if (!bank_mask[acc_addr[15:14]]) begin
                exp_delay = 0; exp_tag = "R4";
            end else if (ln >= 192 || col >= span_of(ref_model)) begin
                exp_delay = 0; exp_tag = "R8";
            end else if (eff(ref_model) == 2) begin
                exp_delay = seq_alt(col % 8); exp_tag = "R5 R7";
            end else begin
                exp_delay = seq_std(col % 8); exp_tag = "R5 R6";
            end
            if (restart_tag > 0) begin exp_tag = "R10"; restart_tag--; end
            // R9 interrupt, R2 geometry
            if (ref_pos == frame - ahead_of(ref_model)) ref_cnt = 32;
            else if (ref_cnt > 0) ref_cnt--;
            exp_irq = (ref_cnt != 0);
            // position update, R10 restart
            if (int'(model_sel) != ref_model) begin
                ref_model = int'(model_sel); ref_pos = 0; restart_tag = 8;
            end else begin
                ref_pos = (ref_pos + 1) % frame;
            end
        end
        cmp_en = 1;
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check(exp_tag, int'(delay_o), exp_delay);
            check("R2 R9", int'(irq_o), exp_irq);
            if (irq_o && !prev_irq) irq_rises++;
            prev_irq = irq_o;
        end
    end

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            acc_valid = ($urandom % 3) != 0;
            acc_addr  = 16'($urandom);
            if (($urandom % 400) == 0) bank_mask = 4'($urandom);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 199000) begin
            n_fail++;
            $display("FAIL watchdog R1..: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state, with an access presented during reset
        repeat (4) begin
            @(negedge clk);
            acc_valid = 1'b1; acc_addr = 16'h4000;
            check("R1", int'(delay_o), 0);
            check("R1", int'(irq_o), 0);
        end
        @(negedge clk);
        acc_valid = 1'b0;
        rst_ni = 1'b1;
        // Model 0: beyond one full frame so the wrap and its interrupt occur
        run(69950);
        // R10: mid-frame switch to model 1
        @(negedge clk); model_sel = 2'd1;
        run(56600);
        // R10: mid-frame switch to model 2
        @(negedge clk); model_sel = 2'd2;
        run(56600);
        // R2: code 3 aliases code 0
        @(negedge clk); model_sel = 2'd3;
        run(2000);
        @(negedge clk);
        check("R9", irq_rises, 3);
        finish_run();
    end

endmodule